// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines, up to 64, and steers them to one processor core. Every line owns a small configuration word, and software writes that word over a plain register bus. Two bits in the word decide whether the line reaches the core's normal interrupt output, its fast interrupt output, both, or neither. A line counts as enabled when at least one of those two bits is set.

A read-only select word lets the interrupt handler learn at once whether any enabled line is requesting and which one to serve. When several lines request together, the lowest-numbered one is named. The select word and both interrupt outputs are formed combinationally from the present inputs and the stored configuration. Nothing is latched, so a request disappears as soon as its input falls, and reading the select word changes nothing.

The block holds no sequencing state. Its only storage is the bank of configuration words, and all other paths are combinational.

Top module: `irqr_ctrl`

## Requirements
- R1: After reset every configuration word reads 0, `irq_o` and `fiq_o` are low, and the select word reads 0 even while every source input is high.
- R2: The configuration word of source n is at byte address 4*n, and address bits 1:0 are ignored. A write stores write-data bits 6:0 and preserves them exactly. A read returns them in bits 6:0, with bits 31:7 reading 0.
- R3: `irq_o` is high exactly when some source input is high and bit 5 of that source's word is set.
- R4: `fiq_o` is high exactly when some source input is high and bit 6 of that source's word is set.
- R5: The select word is at byte address 0x104. Its bit 6 is high exactly when some source input is high and bit 5 or bit 6 of that source's word is set. Bits 31:7 read 0.
- R6: While select bit 6 is high, select bits 5:0 hold the lowest number among the requesting enabled sources.
- R7: Requests are level-sensitive and are not held. When a source input falls, its effect on `irq_o`, `fiq_o` and the select word is gone in the same cycle.
- R8: Reading the select word has no side effects. Back-to-back reads with unchanged inputs return the same value, and no configuration word changes.
- R9: A write to the select address, or to any byte address whose word index is not below the source count, changes no configuration word.
- R10: A source whose word has bits 5 and 6 both clear does not affect the outputs or the select word, whatever its other bits hold. Writing 0 to a word disables that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level interrupt inputs, bit n is source n |
| bus_wr | input | 1 | Write strobe, the write takes effect at the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
The bench builds the block with its defaults: 64 sources and a 12-bit address. With 64 sources the last configuration word sits at 0xFC, just below the select word at 0x104. Source 63 then fills the whole 6-bit number field, and both the highest and the lowest source index can win the priority choice. The 12-bit address also reaches word indices above the select word, so writes to unmapped space can be shown to be dropped.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    // width of a stored configuration word
    localparam int CFG_W      = 7;
    // route bits inside a configuration word
    localparam int IRQ_BIT    = 5;
    localparam int FIQ_BIT    = 6;
    // select word layout
    localparam int NUM_W      = 6;
    localparam int PEND_BIT   = 6;
    localparam int SEL_OFFSET = 'h104;
    localparam int BUS_W      = 32;
endpackage

// File: rtl/irqr_cfg_bank.sv
module irqr_cfg_bank
    import irqr_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int WIDX_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [WIDX_W-1:0]        widx_i,
    input  logic [CFG_W-1:0]         wdata_i,
    output logic [NSRC*CFG_W-1:0]    cfg_flat_o
);
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_word
            logic hit;
            assign hit = wr_i && (widx_i == WIDX_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_flat_o[g*CFG_W +: CFG_W] <= '0;
                end else if (hit) begin
                    cfg_flat_o[g*CFG_W +: CFG_W] <= wdata_i;
                end
            end
        end
    endgenerate

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_flat_o));

    // R9
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (widx_i >= WIDX_W'(NSRC))) |=> $stable(cfg_flat_o));
endmodule

// File: rtl/irqr_route.sv
module irqr_route
    import irqr_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0]       src_i,
    input  logic [NSRC*CFG_W-1:0] cfg_flat_i,
    output logic [NSRC-1:0]       pend_o,
    output logic                  irq_o,
    output logic                  fiq_o
);
    logic [NSRC-1:0] irq_vec;
    logic [NSRC-1:0] fiq_vec;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign irq_vec[g] = src_i[g] & cfg_flat_i[g*CFG_W + IRQ_BIT];
            assign fiq_vec[g] = src_i[g] & cfg_flat_i[g*CFG_W + FIQ_BIT];
        end
    endgenerate

    assign pend_o = irq_vec | fiq_vec;
    assign irq_o  = |irq_vec;
    assign fiq_o  = |fiq_vec;
endmodule

// File: rtl/irqr_pick.sv
module irqr_pick
    import irqr_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             valid_o,
    output logic [NUM_W-1:0] num_o
);
    always_comb begin
        num_o = '0;
        // scan downward so the lowest set index is written last
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                num_o = NUM_W'(i);
            end
        end
    end

    assign valid_o = |pend_i;
endmodule

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
    import irqr_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int WIDX_W   = ADDR_W - 2;
    localparam int SEL_WIDX = SEL_OFFSET / 4;

    logic [WIDX_W-1:0]        widx;
    logic [NSRC*CFG_W-1:0]    cfg_flat;
    logic [NSRC-1:0]          pend_vec;
    logic                     sel_valid;
    logic [NUM_W-1:0]         sel_num;
    logic                     unused_bits;

    assign widx        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CFG_W]};

    irqr_cfg_bank #(.NSRC(NSRC), .WIDX_W(WIDX_W)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .widx_i     (widx),
        .wdata_i    (bus_wdata[CFG_W-1:0]),
        .cfg_flat_o (cfg_flat)
    );

    irqr_route #(.NSRC(NSRC)) route_i (
        .src_i      (src_i),
        .cfg_flat_i (cfg_flat),
        .pend_o     (pend_vec),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    irqr_pick #(.NSRC(NSRC)) pick_i (
        .pend_i  (pend_vec),
        .valid_o (sel_valid),
        .num_o   (sel_num)
    );

    always_comb begin
        bus_rdata = '0;
        if (widx == WIDX_W'(SEL_WIDX)) begin
            bus_rdata[PEND_BIT]    = sel_valid;
            bus_rdata[NUM_W-1:0]   = sel_num;
        end else if (widx < WIDX_W'(NSRC)) begin
            bus_rdata[CFG_W-1:0]   = cfg_flat[int'(widx)*CFG_W +: CFG_W];
        end
    end

    // R5
    flag_vs_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) == sel_valid);

    // R6
    pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> pend_vec[sel_num]);

    // R6
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ((pend_vec & ((NSRC'(1) << sel_num) - NSRC'(1))) == '0));
endmodule

// File: tb/irqr_ctrl_tb_top.sv
module irqr_ctrl_tb_top;
    localparam int NSRC   = 64;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] SEL_A = 12'h104;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NSRC-1:0]   src;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic              irq, fiq;

    always #10 clk = ~clk;

    irqr_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    logic [6:0]  model_cfg [NSRC];
    logic [33:0] exp_q [$];
    string       tag_q [$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int i = 0; i < NSRC; i++) r |= src[i] & model_cfg[i][5];
        return r;
    endfunction

    function automatic logic m_fiq();
        logic r = 1'b0;
        for (int i = 0; i < NSRC; i++) r |= src[i] & model_cfg[i][6];
        return r;
    endfunction

    function automatic logic [31:0] m_sel();
        for (int i = 0; i < NSRC; i++)
            if (src[i] && (model_cfg[i][5] || model_cfg[i][6]))
                return 32'h40 | 32'(i);
        return 32'h0;
    endfunction

    function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
        int w = int'(a >> 2);
        if (w == 'h104 / 4) return m_sel();
        if (w < NSRC) return {25'b0, model_cfg[w]};
        return 32'h0;
    endfunction

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        int w;
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        w = int'(a >> 2);
        if (w < NSRC) model_cfg[w] = d[6:0];
    endtask

    task automatic set_src(logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
    endtask

    // driver: place a read and push the expected outputs
    task automatic check(logic [ADDR_W-1:0] a, string tag);
        @(negedge clk);
        addr = a;
        exp_q.push_back({m_read(a), m_irq(), m_fiq()});
        tag_q.push_back(tag);
    endtask

    // monitor: pop and compare a quarter period before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({rdata, irq, fiq} !== e) begin
                    failures++;
                    $display("FAIL %s addr=%h: rdata=%h irq=%b fiq=%b expected rdata=%h irq=%b fiq=%b",
                             t, addr, rdata, irq, fiq, e[33:2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src = '0; wr = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < NSRC; i++) model_cfg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R10: everything disabled after reset
        set_src('1);
        check(12'h000, "R1 cfg0");
        check(12'h0FC, "R1 cfg63");
        check(SEL_A,   "R1 select");
        set_src('0);

        // R3, R5, R6: source 3 on the normal line
        bus_write(12'h00C, 32'h20);
        set_src(64'h8);
        check(12'h00C, "R2 cfg3 readback");
        check(SEL_A,   "R3 R5 select src3");

        // R4: source 10 on the fast line, source 3 still lower
        bus_write(12'h028, 32'h40);
        set_src(64'h408);
        check(SEL_A, "R4 R6 select both");
        set_src(64'h400);
        check(SEL_A, "R4 fast only");

        // R2: upper bits dropped, source 63 fills the number field
        bus_write(12'h0FF, 32'hFFFF_FFFF);
        check(12'h0FC, "R2 cfg63 upper bits");
        set_src(64'h8000_0000_0000_0000);
        check(SEL_A, "R6 select src63");

        // R6, R7: priority shifts as lines fall
        set_src(64'h8000_0000_0000_0408);
        check(SEL_A, "R6 lowest of three");
        set_src(64'h8000_0000_0000_0400);
        check(SEL_A, "R7 after src3 falls");
        set_src(64'h8000_0000_0000_0000);
        check(SEL_A, "R7 after src10 falls");
        set_src('0);
        check(SEL_A, "R7 all fallen");

        // R10: non-route bits only
        bus_write(12'h000, 32'h5F);
        bus_write(12'h000, 32'h1F);
        set_src(64'h1);
        check(SEL_A,   "R10 src0 not enabled");
        check(12'h000, "R10 cfg0 other bits kept");

        // R9: writes to select and unmapped space
        bus_write(SEL_A,   32'h0);
        bus_write(12'h200, 32'h0);
        bus_write(12'h108, 32'h0);
        set_src(64'h9);
        check(12'h00C, "R9 cfg3 unchanged");
        check(SEL_A,   "R9 select src3");

        // R8: repeated reads
        check(SEL_A,   "R8 read one");
        check(SEL_A,   "R8 read two");
        check(12'h00C, "R8 cfg3 after reads");

        // R10: disabling by writing 0
        bus_write(12'h00C, 32'h0);
        check(SEL_A, "R10 src3 disabled");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule